// File: doc/BRIEF.md
# Debounced Differential Clock Stop Controller

The block produces several differential clock pairs (a true and a complement level) from one reference clock. An asynchronous, active-low stop request can halt a chosen subset of those pairs. Every pair has a configuration bit that marks it either stoppable or free-running. A stoppable pair halts cleanly, without a shortened pulse. It stays parked in one of two states, selected by a global mode bit. It restarts together with all the other stopped pairs once the request is withdrawn. Each pair also has an override input that forces it fully off whatever the stop logic is doing.

The pairs are modelled as registered logic levels, and each level has a drive-enable flag beside it. Each pair toggles once per reference cycle, so one output period is two reference cycles. A "complement rising edge" is the reference edge at which the true level falls from 1 to 0. The stop request first passes through a synchronizer. It then has to show the same level at two consecutive complement rising edges before the controller accepts it.

Top module: `dclk_stop`

## Requirements
- R1: Driving `stopReqN` low and holding it parks every stoppable pair that is not overridden. The request may change at any time relative to `clk`.
- R2: A change of the synchronized request is accepted only if it shows the same level at two consecutive complement rising edges. A low pulse on `stopReqN` that lasts one reference cycle has no visible effect, and stoppable pairs keep `compDrv` at 1.
- R3: A pair with `stopEn` at 0 toggles `difTrue` every reference cycle whatever the request and `parkTri` are.
- R4: A stopped pair first completes the half period it is in. With `parkTri`=0, the cycle just before parking shows `difTrue`=0. With `parkTri`=1, that cycle shows `difTrue`=1.
- R5: With `parkTri`=0, a parked pair shows `difTrue`=1 with `trueDrv`=1, and `difComp`=0 with `compDrv`=0.
- R6: With `parkTri`=1, a parked pair shows `difTrue`, `difComp`, `trueDrv` and `compDrv` all at 0.
- R7: `forceOff[i]`=1 drives all four outputs of pair i to 0, whatever the request and the mode.
- R8: After the request is released, every stopped pair resumes in the same reference cycle, starting with `difTrue`=1. This happens 4 to 12 reference cycles (2 to 6 output periods) after `stopReqN` rises.
- R9: During reset, which is asynchronous and active low on `rstN`, every pair that is not overridden shows `difTrue`=0, `difComp`=1, `trueDrv`=1 and `compDrv`=1.
- R10: A running pair drives both flags at 1, keeps `difComp` equal to the inverse of `difTrue`, and toggles every reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stopReqN | input | 1 | Asynchronous stop request, active low |
| parkTri | input | 1 | Park style for stopped pairs: 0 driven, 1 undriven |
| stopEn | input | NUM_PAIRS | Per pair: 1 stoppable, 0 free-running |
| forceOff | input | NUM_PAIRS | Per pair override: 1 forces the pair undriven |
| difTrue | output | NUM_PAIRS | True output level |
| difComp | output | NUM_PAIRS | Complement output level |
| trueDrv | output | NUM_PAIRS | Drive enable of the true output |
| compDrv | output | NUM_PAIRS | Drive enable of the complement output |

## Verification
The phase register and the park state change on the rising edge of `clk`. The outputs follow them and the override combinationally, so each result is due in the same cycle as the edge that causes it. The bench reads the outputs at the following falling edge. A request driven at a falling edge passes two synchronizer stages and then two spaced samples, so its effect lands several cycles later. The bench's cycle model advances on every rising edge in the same order, which keeps the expected value aligned to that cycle. The restart latency is counted in falling edges from the release and must fall between 4 and 12.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // Strobes handed from the stop controller to the lane datapath.
  typedef struct packed {
    logic phaseHi;   // free-running true level for this cycle
    logic parkHold;  // stoppable lanes are held in their park state
  } dcs_strobe_t;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_PARK = 1'b1
  } dcs_state_t;
endpackage

// File: rtl/dclk_stop_ctrl.sv
module dclk_stop_ctrl
  import dcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopReqN,
  input  logic        parkTri,
  output dcs_strobe_t strb
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncQ;
  logic              reqSync;
  logic              sampQ;
  logic              stopValid;
  logic              phase;
  logic              nextPhase;
  logic              parkLevel;
  dcs_state_t        state;
  dcs_state_t        stateNxt;

  assign reqSync   = syncQ[SYNC_MSB];
  assign nextPhase = ~phase;
  assign parkLevel = ~parkTri;

  // Request synchronizer, stop asserted high internally.
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_MSB-1:0], ~stopReqN};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= ~stopReqN;
      end
    end
  endgenerate

  // Output phase: true level toggles every reference cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= nextPhase;
  end

  // Debounce: sample at complement rising edges (true falling), accept two equal samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampQ     <= 1'b0;
      stopValid <= 1'b0;
    end else if (phase) begin
      sampQ <= reqSync;
      if (reqSync == sampQ) stopValid <= reqSync;
    end
  end

  // Park state: enter on the edge that lands on the park level, leave where true rises.
  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:  if (stopValid && (nextPhase == parkLevel)) stateNxt = ST_PARK;
      ST_PARK: if (!stopValid && nextPhase)               stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  assign strb.phaseHi  = phase;
  assign strb.parkHold = (state == ST_PARK);

  AST_DEBOUNCE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopValid) |-> ($past(reqSync) && $past(reqSync, 3))); // R2
  AST_DEBOUNCE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopValid) |-> (!$past(reqSync) && !$past(reqSync, 3))); // R2
  AST_PARK_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.parkHold) |-> (phase == !$past(parkTri))); // R4
  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.parkHold) |-> phase); // R8
  AST_RESTART_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.parkHold) |-> !$past(stopValid)); // R8
endmodule

// File: rtl/dclk_stop_lanes.sv
module dclk_stop_lanes
  import dcs_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dcs_strobe_t          strb,
  input  logic                 parkTri,
  input  logic [NUM_PAIRS-1:0] stopEn,
  input  logic [NUM_PAIRS-1:0] forceOff,
  output logic [NUM_PAIRS-1:0] difTrue,
  output logic [NUM_PAIRS-1:0] difComp,
  output logic [NUM_PAIRS-1:0] trueDrv,
  output logic [NUM_PAIRS-1:0] compDrv
);
  generate
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_lane
      logic held;
      assign held = stopEn[i] & strb.parkHold;

      always_comb begin
        if (forceOff[i]) begin
          difTrue[i] = 1'b0;
          difComp[i] = 1'b0;
          trueDrv[i] = 1'b0;
          compDrv[i] = 1'b0;
        end else if (held) begin
          difTrue[i] = ~parkTri;
          difComp[i] = 1'b0;
          trueDrv[i] = ~parkTri;
          compDrv[i] = 1'b0;
        end else begin
          difTrue[i] = strb.phaseHi;
          difComp[i] = ~strb.phaseHi;
          trueDrv[i] = 1'b1;
          compDrv[i] = 1'b1;
        end
      end

      AST_OVERRIDE_OFF: assert property (@(posedge clk) disable iff (!rstN)
        forceOff[i] |-> !(difTrue[i] | difComp[i] | trueDrv[i] | compDrv[i])); // R7
      AST_PARK_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
        (strb.parkHold && stopEn[i] && !forceOff[i] && !parkTri)
          |-> (difTrue[i] && trueDrv[i] && !difComp[i] && !compDrv[i])); // R5
      AST_PARK_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
        (strb.parkHold && stopEn[i] && !forceOff[i] && parkTri)
          |-> !(difTrue[i] | difComp[i] | trueDrv[i] | compDrv[i])); // R6
      AST_RUN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
        (trueDrv[i] && compDrv[i]) |-> (difComp[i] == !difTrue[i])); // R10
      AST_FREE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !stopEn[i] && !forceOff[i] && $past(!stopEn[i] && !forceOff[i]))
          |-> (difTrue[i] != $past(difTrue[i]))); // R3
    end
  endgenerate
endmodule

// File: rtl/dclk_stop.sv
module dclk_stop
  import dcs_pkg::*;
#(
  parameter int NUM_PAIRS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stopReqN,
  input  logic                 parkTri,
  input  logic [NUM_PAIRS-1:0] stopEn,
  input  logic [NUM_PAIRS-1:0] forceOff,
  output logic [NUM_PAIRS-1:0] difTrue,
  output logic [NUM_PAIRS-1:0] difComp,
  output logic [NUM_PAIRS-1:0] trueDrv,
  output logic [NUM_PAIRS-1:0] compDrv
);
  dcs_strobe_t strb;

  dclk_stop_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stopReqN (stopReqN),
    .parkTri  (parkTri),
    .strb     (strb)
  );

  dclk_stop_lanes #(
    .NUM_PAIRS(NUM_PAIRS)
  ) u_lanes (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .parkTri  (parkTri),
    .stopEn   (stopEn),
    .forceOff (forceOff),
    .difTrue  (difTrue),
    .difComp  (difComp),
    .trueDrv  (trueDrv),
    .compDrv  (compDrv)
  );
endmodule

// File: tb/tb_dclk_stop.sv
`timescale 1ns/1ps
module tb_dclk_stop;
  localparam int N      = 4;
  localparam int CLK_NS = 20;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stopReqN = 1'b1;
  logic         parkTri = 1'b0;
  logic [N-1:0] stopEn = 4'b0111;
  logic [N-1:0] forceOff = '0;
  logic [N-1:0] difTrue, difComp, trueDrv, compDrv;

  int checks = 0;
  int errors = 0;

  dclk_stop #(.NUM_PAIRS(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .stopReqN(stopReqN), .parkTri(parkTri),
    .stopEn(stopEn), .forceOff(forceOff),
    .difTrue(difTrue), .difComp(difComp), .trueDrv(trueDrv), .compDrv(compDrv)
  );

  always #(CLK_NS/2) clk = ~clk;

  // Cycle model written from the requirements.
  logic mS1 = 0, mS2 = 0, mSamp = 0, mValid = 0, mPhase = 0, mParked = 0;
  always @(posedge clk or negedge rstN) begin : model
    logic nP;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mSamp = 0; mValid = 0; mPhase = 0; mParked = 0;
    end else begin
      nP = ~mPhase;
      if (!mParked && mValid && (nP == ~parkTri)) mParked = 1'b1;
      else if (mParked && !mValid && nP)          mParked = 1'b0;
      if (mPhase) begin
        if (mS2 == mSamp) mValid = mS2;
        mSamp = mS2;
      end
      mS2 = mS1;
      mS1 = ~stopReqN;
      mPhase = nP;
    end
  end

  function automatic logic [3:0] expLane(int i);
    if (forceOff[i])            return 4'b0000;
    if (stopEn[i] && mParked)   return {~parkTri, 1'b0, ~parkTri, 1'b0};
    return {mPhase, ~mPhase, 2'b11};
  endfunction

  function automatic logic [3:0] actLane(int i);
    return {difTrue[i], difComp[i], trueDrv[i], compDrv[i]};
  endfunction

  task automatic report(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance to the next falling edge and compare every lane with the model.
  task automatic tick();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      string tag;
      if (forceOff[i])      tag = "R7 override";
      else if (!stopEn[i])  tag = "R3 free-running";
      else if (mParked)     tag = parkTri ? "R6 park float" : "R5 park driven";
      else                  tag = "R10 running";
      report(actLane(i) == expLane(i), tag, actLane(i), expLane(i));
    end
  endtask

  // Stop and verify the half period completed before parking (lane 0 is stoppable).
  task automatic stopAndPark();
    logic prevCd, prevTrue;
    bit   seen;
    seen = 0;
    prevCd = compDrv[0];
    prevTrue = difTrue[0];
    stopReqN = 1'b0;
    for (int k = 0; k < 16; k++) begin
      tick();
      if (!seen && prevCd && !compDrv[0]) begin
        seen = 1;
        report(prevTrue == parkTri, "R4 full half period before park", prevTrue, parkTri);
      end
      prevCd = compDrv[0];
      prevTrue = difTrue[0];
    end
    report(seen, "R1 stoppable pair parked", seen, 1);
  endtask

  task automatic measureRestart();
    int           lat;
    bit           partial;
    logic [N-1:0] cd;
    lat = 0;
    partial = 0;
    stopReqN = 1'b1;
    do begin
      tick();
      lat++;
      cd = compDrv & stopEn;
      if (cd != '0 && cd != stopEn) partial = 1;
    end while (cd != stopEn && lat < 40);
    report(lat >= 4 && lat <= 12, "R8 restart latency in cycles", lat, 8);
    report(!partial, "R8 all pairs restart together", partial, 0);
    report((difTrue & stopEn) == stopEn, "R8 restart begins high", difTrue & stopEn, stopEn);
  endtask

  initial begin : watchdog
    #(CLK_NS * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic lastT;
    void'($urandom(32'd20240611));
    // Reset state (R9)
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++)
      report(actLane(i) == 4'b0111, "R9 reset state", actLane(i), 4'b0111);
    rstN = 1'b1;
    repeat (6) tick();

    // One-cycle request pulse must be filtered (R2)
    stopReqN = 1'b0;
    tick();
    stopReqN = 1'b1;
    for (int k = 0; k < 14; k++) begin
      tick();
      report(compDrv[0] == 1'b1, "R2 short pulse ignored", compDrv[0], 1);
    end

    // Driven park (R1, R4, R5), free lane keeps toggling (R3)
    parkTri = 1'b0;
    stopAndPark();
    report(actLane(1) == 4'b1010, "R5 driven park levels", actLane(1), 4'b1010);
    lastT = difTrue[3];
    tick();
    report(difTrue[3] != lastT, "R3 free pair toggles while others stopped", difTrue[3], !lastT);
    measureRestart();
    repeat (4) tick();

    // Undriven park (R6)
    parkTri = 1'b1;
    repeat (2) tick();
    stopAndPark();
    report(actLane(2) == 4'b0000, "R6 float park levels", actLane(2), 4'b0000);
    measureRestart();
    repeat (4) tick();

    // Override precedence (R7)
    parkTri = 1'b0;
    stopAndPark();
    forceOff = 4'b1001;
    tick();
    report(actLane(0) == 4'b0000, "R7 override on parked pair", actLane(0), 4'b0000);
    report(actLane(3) == 4'b0000, "R7 override on free pair", actLane(3), 4'b0000);
    forceOff = '0;
    tick();
    measureRestart();

    // Constrained random segments checked against the model every cycle
    for (int s = 0; s < 300; s++) begin
      int hold;
      int pick;
      stopReqN = 1'($urandom_range(0, 1));
      hold = $urandom_range(1, 14);
      pick = $urandom_range(0, 15);
      if (pick == 0)      forceOff = N'($urandom_range(0, (1 << N) - 1));
      else if (pick == 1) forceOff = '0;
      else if (pick == 2) stopEn = N'($urandom_range(0, (1 << N) - 1));
      else if (pick == 3) parkTri = ~parkTri;
      repeat (hold) tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule